// File: doc/BRIEF.md
# Legacy memory region attribute decoder

This block sorts every memory access by address and returns the attributes that govern it. The space from 640 KB up to 1 MB holds nineteen controlled regions. Three are graphics windows of unequal size: one of 64 KB and two of 32 KB. The other sixteen are 16 KB segments covering C0000h to FFFFFh. Each region holds four permission bits. Each graphics window also holds a bit that steers its accesses to the graphics pipeline. A top-of-memory register marks where system memory ends. An address at or above that value is flagged as outside memory and gets no attributes.

An optional mask can clear address bit 20 on every access that is not an SMI cycle. This keeps software that relies on the address wrapping at 1 MB working. The decode path is purely combinational, so the attributes and the reject flag follow the presented address in the same cycle. A simple register write port loads the control state, and a written value takes effect one clock later.

The access side has no valid/ready handshake. `acc_valid` only qualifies `reject`. The block holds no transfer, so it never applies back-pressure, and an access may be presented every cycle.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset, every region attribute bit, every steer bit and the A20 mask are 0, and top-of-memory equals the parameter TOM_RESET (default 0100_0000h). A read in a legacy region is therefore rejected, while a read below A0000h is accepted.
- R2: When the effective address is below top-of-memory, `legacy_hit` is 1 for A0000h..FFFFFh and `region_idx` gives the region. A0000h..AFFFFh is index 0, B0000h..B7FFFh is index 1 and B8000h..BFFFFh is index 2. The segment at C0000h + k*4000h (k = 0..15) is index 3+k. Outside the legacy window `legacy_hit` is 0 and `region_idx` is 0.
- R3: Each region register holds its attributes at these bit positions: bit 0 is read permit (`rd_ok`), bit 1 is write permit (`wr_ok`), bit 2 is `cacheable` and bit 3 is external master permit (`pci_ok`). All four bits are independent.
- R4: Control register bits 3:1 are the steer bits for regions 0, 1 and 2, in that order. `gfx_steer` is 1 only for an access in a graphics window whose steer bit is set.
- R5: Control register bit 0 is the A20 mask. When it is set, a non-SMI access has address bit 20 cleared before decoding. An SMI access is decoded unchanged.
- R6: An effective address at or above top-of-memory sets `outside`, and all attribute outputs are 0. Top-of-memory is checked before the region map.
- R7: An effective address below A0000h, or from 100000h up to top-of-memory, gets full access: `rd_ok`, `wr_ok`, `cacheable` and `pci_ok` are all 1, and `gfx_steer` is 0.
- R8: `reject` is 1 in the same cycle when `acc_valid` is 1 and either of two conditions holds. The first is that the access lacks its permit (`wr_ok` for a write, `rd_ok` for a read). The second is that `ext_master` is 1 while `pci_ok` is 0. `reject` is 0 whenever `acc_valid` is 0.
- R9: The register map is: address 0 is control, address 1 is top-of-memory (full address) and addresses 2..20 are regions 0..18 (data bits 3:0). A write takes effect from the clock edge that samples `cfg_we`. Writes to addresses 21..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | ADDR_W | Register write data |
| acc_valid | input | 1 | Access present; qualifies reject |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_smi | input | 1 | Access is an SMI cycle |
| ext_master | input | 1 | Access comes from an external bus master |
| rd_ok | output | 1 | Read permitted |
| wr_ok | output | 1 | Write permitted |
| cacheable | output | 1 | Access may be cached |
| pci_ok | output | 1 | External master access permitted |
| gfx_steer | output | 1 | Route access to the graphics pipeline |
| outside | output | 1 | Address at or above top-of-memory |
| legacy_hit | output | 1 | Address falls in a legacy region |
| region_idx | output | 5 | Region index when legacy_hit is 1 |
| reject | output | 1 | Presented access is not allowed |

## Verification
All access outputs are combinational and due in the same cycle as the address. The bench drives each access on the falling edge and compares one time unit later, before the next rising edge. A register write is due one rising edge after it is driven. The bench drives the write on a falling edge, lets one rising edge pass, and only then presents the accesses that depend on it, at the next falling edge. The reference model takes its own register copy from the bench's write calls, never from the design.

// File: rtl/legacy_region_pkg.sv
package legacy_region_pkg;
  localparam int NUM_VGA  = 3;
  localparam int NUM_SEG  = 16;
  localparam int NUM_REG  = NUM_VGA + NUM_SEG;
  localparam int IDX_W    = 5;
  localparam int CFG_AW   = 5;
  localparam int SEG_SHIFT = 14;

  localparam logic [CFG_AW-1:0] CFG_CTRL  = 5'd0;
  localparam logic [CFG_AW-1:0] CFG_TOM   = 5'd1;
  localparam logic [CFG_AW-1:0] CFG_ATTR0 = 5'd2;
  localparam logic [CFG_AW-1:0] CFG_LAST  = CFG_ATTR0 + CFG_AW'(NUM_REG - 1);

  typedef struct packed {
    logic pci;
    logic cache;
    logic wr;
    logic rd;
  } reg_attr_t;

  typedef enum logic [1:0] {
    CLS_LOW    = 2'd0,
    CLS_LEGACY = 2'd1,
    CLS_HIGH   = 2'd2,
    CLS_OUT    = 2'd3
  } acc_class_t;
endpackage

// File: rtl/legacy_region_cfg.sv
module legacy_region_cfg
  import legacy_region_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] TOM_RESET = 32'h0100_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output logic                  a20_mask,
  output logic [NUM_VGA-1:0]    steer,
  output logic [ADDR_W-1:0]     tom,
  output reg_attr_t [NUM_REG-1:0] attr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a20_mask <= 1'b0;
      steer    <= '0;
    end else if (cfg_we && cfg_addr == CFG_CTRL) begin
      a20_mask <= cfg_wdata[0];
      steer    <= cfg_wdata[NUM_VGA:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tom <= TOM_RESET;
    else if (cfg_we && cfg_addr == CFG_TOM) tom <= cfg_wdata;
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_attr
    localparam logic [CFG_AW-1:0] MY_ADDR = CFG_ATTR0 + CFG_AW'(r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attr[r] <= '0;
      else if (cfg_we && cfg_addr == MY_ADDR) attr[r] <= reg_attr_t'(cfg_wdata[3:0]);
    end
  end

  // R9
  tom_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_TOM) |=> tom == $past(cfg_wdata));

  // R9
  bad_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > CFG_LAST) |=> ($stable(attr) && $stable(tom) && $stable(steer) && $stable(a20_mask)));

endmodule

// File: rtl/legacy_region_map.sv
module legacy_region_map
  import legacy_region_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smi,
  input  logic              a20_mask,
  input  logic [ADDR_W-1:0] tom,
  output acc_class_t        cls,
  output logic [IDX_W-1:0]  idx
);

  logic [ADDR_W-1:0] ea;
  logic              upper_zero;
  logic              in_vga;
  logic              in_seg;

  always_comb begin
    ea = addr;
    if (a20_mask && !smi) ea[20] = 1'b0;
  end

  assign upper_zero = (ea[ADDR_W-1:20] == '0);
  assign in_vga     = upper_zero && (ea[19:17] == 3'b101);
  assign in_seg     = upper_zero && (ea[19:18] == 2'b11);

  always_comb begin
    if (ea >= tom)              cls = CLS_OUT;
    else if (in_vga || in_seg)  cls = CLS_LEGACY;
    else if (upper_zero)        cls = CLS_LOW;
    else                        cls = CLS_HIGH;
  end

  always_comb begin
    idx = '0;
    if (cls == CLS_LEGACY) begin
      if (in_seg)         idx = IDX_W'(NUM_VGA) + {1'b0, ea[SEG_SHIFT+3:SEG_SHIFT]};
      else if (!ea[16])   idx = 5'd0;
      else if (!ea[15])   idx = 5'd1;
      else                idx = 5'd2;
    end
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_LEGACY) |-> (idx < IDX_W'(NUM_REG)));

  // R5
  a20_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a20_mask && !smi && addr[ADDR_W-1:21] == '0 && addr[20] && addr[19:17] == 3'b000 && addr < tom)
      |-> (cls == CLS_LOW));

endmodule

// File: rtl/legacy_region_attr.sv
module legacy_region_attr
  import legacy_region_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  acc_class_t              cls,
  input  logic [IDX_W-1:0]        idx,
  input  reg_attr_t [NUM_REG-1:0] attr,
  input  logic [NUM_VGA-1:0]      steer,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic                    ext_master,
  output logic                    rd_ok,
  output logic                    wr_ok,
  output logic                    cacheable,
  output logic                    pci_ok,
  output logic                    gfx_steer,
  output logic                    outside,
  output logic                    reject
);

  reg_attr_t sel;
  logic      allowed;

  always_comb begin
    sel       = '0;
    gfx_steer = 1'b0;
    unique case (cls)
      CLS_LOW, CLS_HIGH: sel = '{pci: 1'b1, cache: 1'b1, wr: 1'b1, rd: 1'b1};
      CLS_LEGACY: begin
        if (idx < IDX_W'(NUM_REG)) sel = attr[idx];
        if (idx < IDX_W'(NUM_VGA)) gfx_steer = steer[idx[1:0]];
      end
      default: sel = '0;
    endcase
  end

  assign rd_ok     = sel.rd;
  assign wr_ok     = sel.wr;
  assign cacheable = sel.cache;
  assign pci_ok    = sel.pci;
  assign outside   = (cls == CLS_OUT);

  assign allowed = (acc_write ? sel.wr : sel.rd) && (!ext_master || sel.pci);
  assign reject  = acc_valid && !allowed;

  // R6
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_OUT) |-> !(rd_ok || wr_ok || cacheable || pci_ok || gfx_steer));

  // R4
  steer_vga_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_steer |-> (cls == CLS_LEGACY && idx < IDX_W'(NUM_VGA)));

  // R8
  reject_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> acc_valid);

  // R7
  default_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_LOW || cls == CLS_HIGH) |-> (rd_ok && wr_ok && cacheable && pci_ok && !gfx_steer));

endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder
  import legacy_region_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] TOM_RESET = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_smi,
  input  logic              ext_master,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              cacheable,
  output logic              pci_ok,
  output logic              gfx_steer,
  output logic              outside,
  output logic              legacy_hit,
  output logic [4:0]        region_idx,
  output logic              reject
);

  logic                    a20_mask;
  logic [NUM_VGA-1:0]      steer;
  logic [ADDR_W-1:0]       tom;
  reg_attr_t [NUM_REG-1:0] attr;
  acc_class_t              cls;
  logic [IDX_W-1:0]        idx;

  legacy_region_cfg #(.ADDR_W(ADDR_W), .TOM_RESET(TOM_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .a20_mask(a20_mask), .steer(steer), .tom(tom), .attr(attr)
  );

  legacy_region_map #(.ADDR_W(ADDR_W)) u_map (
    .clk(clk), .rst_n(rst_n), .addr(acc_addr), .smi(acc_smi),
    .a20_mask(a20_mask), .tom(tom), .cls(cls), .idx(idx)
  );

  legacy_region_attr u_attr (
    .clk(clk), .rst_n(rst_n), .cls(cls), .idx(idx), .attr(attr), .steer(steer),
    .acc_valid(acc_valid), .acc_write(acc_write), .ext_master(ext_master),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .cacheable(cacheable), .pci_ok(pci_ok),
    .gfx_steer(gfx_steer), .outside(outside), .reject(reject)
  );

  assign legacy_hit = (cls == CLS_LEGACY);
  assign region_idx = idx;

endmodule

// File: tb/legacy_region_decoder_tb.sv
module legacy_region_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic acc_valid = 0, acc_write = 0, acc_smi = 0, ext_master = 0;
  logic [AW-1:0] acc_addr = 0;
  logic rd_ok, wr_ok, cacheable, pci_ok, gfx_steer, outside, legacy_hit, reject;
  logic [4:0] region_idx;

  int n_chk = 0, n_fail = 0;

  logic m_a20;
  logic [2:0] m_steer;
  logic [AW-1:0] m_tom;
  logic [3:0] m_attr [19];

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_region_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_smi(acc_smi),
    .ext_master(ext_master), .rd_ok(rd_ok), .wr_ok(wr_ok), .cacheable(cacheable),
    .pci_ok(pci_ok), .gfx_steer(gfx_steer), .outside(outside), .legacy_hit(legacy_hit),
    .region_idx(region_idx), .reject(reject)
  );

  function automatic logic [AW-1:0] reg_lo(int i);
    if (i == 0) return 32'h000A_0000;
    if (i == 1) return 32'h000B_0000;
    if (i == 2) return 32'h000B_8000;
    return 32'h000C_0000 + 32'(i - 3) * 32'h4000;
  endfunction

  function automatic logic [AW-1:0] reg_hi(int i);
    if (i == 18) return 32'h0010_0000;
    return reg_lo(i + 1);
  endfunction

  // {legacy, idx[4:0], rd, wr, cache, pci, steer, outside, reject}
  function automatic logic [12:0] ref_out(logic [AW-1:0] a, logic wr, logic smi, logic pm, logic v);
    logic [AW-1:0] ea;
    logic lg, r, w, c, p, s, o;
    logic [4:0] ix;
    ea = a;
    if (m_a20 && !smi) ea[20] = 1'b0;
    {lg, r, w, c, p, s, o} = '0;
    ix = 0;
    if (ea >= m_tom) o = 1;
    else if (ea >= 32'h000A_0000 && ea < 32'h0010_0000) begin
      lg = 1;
      for (int i = 0; i < 19; i++)
        if (ea >= reg_lo(i) && ea < reg_hi(i)) ix = 5'(i);
      {p, c, w, r} = m_attr[ix];
      s = (ix < 3) ? m_steer[ix] : 1'b0;
    end else {r, w, c, p} = 4'hF;
    return {lg, ix, r, w, c, p, s, o, v && (!(wr ? w : r) || (pm && !p))};
  endfunction

  task automatic wr_cfg(logic [4:0] a, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a == 0) begin m_a20 = d[0]; m_steer = d[3:1]; end
    else if (a == 1) m_tom = d;
    else if (a <= 20) m_attr[a-2] = d[3:0];
  endtask

  task automatic chk(string tag, logic [AW-1:0] a, logic wr, logic smi, logic pm, logic v);
    logic [12:0] exp, act;
    @(negedge clk);
    acc_addr = a; acc_write = wr; acc_smi = smi; ext_master = pm; acc_valid = v;
    #1;
    exp = ref_out(a, wr, smi, pm, v);
    act = {legacy_hit, region_idx, rd_ok, wr_ok, cacheable, pci_ok, gfx_steer, outside, reject};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0d smi=%0d pm=%0d actual=%b expected=%b", tag, a, wr, smi, pm, act, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 19; i++) begin
      chk(tag, reg_lo(i), 1'b0, 1'b0, 1'b0, 1'b1);
      chk(tag, reg_hi(i) - 1, 1'b1, 1'b0, 1'b1, 1'b1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [AW-1:0] ra;
    seed = 32'h1357_2468;
    void'($urandom(seed));
    m_a20 = 0; m_steer = 0; m_tom = 32'h0100_0000;
    for (int i = 0; i < 19; i++) m_attr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1", 32'h0000_0500, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1", 32'h000A_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1", 32'h00FF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R1", 32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    sweep("R1");

    // R2 R3 boundaries with random attributes
    for (int i = 0; i < 19; i++) wr_cfg(5'(i + 2), 32'($urandom_range(0, 15)));
    sweep("R2");
    chk("R2", 32'h0009_FFFF, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2", 32'h0010_0000, 1'b0, 1'b0, 1'b0, 1'b1);

    // R3 R8 every attribute combination in every region
    for (int i = 0; i < 19; i++)
      for (int v = 0; v < 16; v++) begin
        wr_cfg(5'(i + 2), 32'(v));
        for (int t = 0; t < 4; t++)
          chk("R3", reg_lo(i) + 32'($urandom_range(0, 32'h3FFF)), t[0], 1'b0, t[1], 1'b1);
        chk("R8", reg_lo(i), 1'b1, 1'b0, 1'b1, 1'b0);
      end

    // R4 steer bits
    for (int s = 0; s < 8; s++) begin
      wr_cfg(5'd0, 32'(s << 1));
      sweep("R4");
    end

    // R5 A20 masking
    wr_cfg(5'd0, 32'h1);
    chk("R5", 32'h001A_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5", 32'h001A_0000, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R5", 32'h0010_0000, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R5", 32'h001F_C000, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5", 32'h0030_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    wr_cfg(5'd0, 32'h0);
    chk("R5", 32'h001A_0000, 1'b0, 1'b0, 1'b0, 1'b1);

    // R6 R7 top of memory
    chk("R7", 32'h0050_0000, 1'b1, 1'b0, 1'b1, 1'b1);
    wr_cfg(5'd1, 32'h000B_0000);
    chk("R6", 32'h000A_FFFF, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6", 32'h000B_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    sweep("R6");
    wr_cfg(5'd1, 32'h0008_0000);
    chk("R6", 32'h0007_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", 32'h0008_0000, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6", 32'h0009_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_cfg(5'd1, 32'h0200_0000);
    chk("R7", 32'h01FF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);

    // R9 writes to unused addresses ignored
    for (int i = 0; i < 19; i++) wr_cfg(5'(i + 2), 32'($urandom_range(0, 15)));
    wr_cfg(5'd0, 32'hE);
    for (int a = 21; a < 32; a++) wr_cfg(5'(a), 32'hFFFF_FFFF);
    sweep("R9");
    chk("R9", 32'h01FF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 19) == 0) begin
        int sel;
        sel = $urandom_range(0, 22);
        if (sel == 22) wr_cfg(5'd1, 32'($urandom_range(32'h0009_0000, 32'h0030_0000)));
        else wr_cfg(5'(sel), 32'($urandom_range(0, 15)));
      end
      case ($urandom_range(0, 2))
        0: ra = 32'($urandom_range(32'h000A_0000, 32'h000F_FFFF));
        1: ra = 32'($urandom_range(32'h0, 32'h0020_0000));
        default: ra = 32'h0010_0000 | 32'($urandom_range(32'h000A_0000, 32'h000F_FFFF));
      endcase
      chk("R8", ra, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule